// File: doc/BRIEF.md
# Sticky Fault Status Register

This block gathers one-cycle event pulses from a set of hardware error detectors into a 64-bit status word. Each detector owns one sticky status bit. The bit stays set until software writes a one to it. A multiple-error flag reports that an uncorrectable or software-correctable error came back while its status bit was still set. A privilege bit records the processor privilege level at the moment of the most recent logged error.

Every event arrives with a two-bit class tag. The bench and the design both use this encoding:
- 00: hardware-corrected
- 01: software-correctable
- 10 and 11: uncorrectable

Two beat markers describe the 16-byte subunits of a 64-byte burst. Once one subunit of a transaction has logged an error, errors in the later subunits of that transaction are dropped. The register is read as one word. Software clears bits by writing ones. A pending output requests a disrupting interrupt while any sticky error bit is set.

Top module: `afsr_fault_status`

## Requirements
- R1: Each event strobe on lane i sets status bit 33+i (lanes 0..18 map to bits 33..51). The bit stays set while no clearing write reaches it.
- R2: A write sets wrEn high for one cycle. Each one in wrData[51:33] clears the matching status bit at the next clock edge, and zeros leave bits unchanged. Reading rdData never changes the register.
- R3: Bits 19:16 and 8:0 are reserved for syndromes that another block captures. They always read zero, and writing ones to them has no effect. Every bit outside 53:33 reads zero.
- R4: Bit 53, the multiple-error flag, is set when an accepted event of class 01, 10 or 11 arrives on a lane whose status bit was already set at the start of that cycle.
- R5: Bit 53 is not set by a class 00 event that repeats on a set bit. It is also not set when events on different lanes set several status bits.
- R6: A cycle with beatValid=1 and beatFirst=1 opens a transaction. After any beat of that transaction has carried an event, the events on its later beats (beatValid=1, beatFirst=0) are dropped. Dropped events set no bit, no multiple-error flag and no privilege bit. Events with beatValid=0 are never dropped.
- R7: Bit 52 takes the value of privLevel in every cycle in which at least one event is accepted.
- R8: Bits 53 and 52 are cleared by writing a one to them. When a clear and a new event reach the same bit in the same cycle, the event wins.
- R9: errPending is high exactly when at least one bit in 51:33 is set.
- R10: During and right after reset, rdData is all zeros and errPending is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errStrobe | input | 19 | One event pulse per detector lane |
| errClass | input | 38 | Two-bit class per lane; lane i uses bits 2i+1:2i |
| privLevel | input | 1 | Current privilege level |
| beatValid | input | 1 | The events this cycle belong to a burst subunit |
| beatFirst | input | 1 | This subunit is the first of a new transaction |
| wrEn | input | 1 | Write strobe |
| wrData | input | 64 | Write data; ones clear bits |
| rdData | output | 64 | Register value |
| errPending | output | 1 | Any sticky error bit set |

## Verification
The bench builds the block with its default parameters. These are the 19 lanes and the fixed bit map, so every lane, the flag bits and the reserved syndrome fields are visible in the single word that is read back. Random stimulus mixes all four class codes, and clearing writes with random data land in the same cycles as new events. This covers clear-versus-event collisions and repeats across classes. Beat sequences with random start markers reach the dropping of later subunits and the reopening of the window at the next transaction.

// File: rtl/afsr_pkg.sv
package afsr_pkg;
  localparam int RegWidth  = 64;
  localparam int ErrCount  = 19;
  localparam int StickyLsb = 33;
  localparam int PrivBit   = 52;
  localparam int MeBit     = 53;

  typedef enum logic [1:0] {
    CLS_HW     = 2'b00,
    CLS_SW     = 2'b01,
    CLS_UE     = 2'b10,
    CLS_UE_ALT = 2'b11
  } errClass_e;

  typedef struct packed {
    logic setMe;
    logic capPriv;
    logic privVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/afsr_ctrl.sv
module afsr_ctrl
  import afsr_pkg::*;
#(
  parameter int ERR_COUNT = ErrCount,
  localparam int ClsWidth = 2 * ERR_COUNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ERR_COUNT-1:0] errStrobe,
  input  logic [ClsWidth-1:0]  errClass,
  input  logic                 privLevel,
  input  logic                 beatValid,
  input  logic                 beatFirst,
  input  logic [ERR_COUNT-1:0] stickyQ,
  output logic [ERR_COUNT-1:0] acceptMask,
  output ctrlStrobe_t          strobes
);
  logic                 burstHitQ;
  logic                 dropNow;
  logic [ERR_COUNT-1:0] repeatLane;

  // Later subunits of a transaction that has already logged an error are dropped.
  assign dropNow    = beatValid & ~beatFirst & burstHitQ;
  assign acceptMask = dropNow ? '0 : errStrobe;

  for (genvar i = 0; i < ERR_COUNT; i++) begin : gLane
    errClass_e laneCls;
    assign laneCls       = errClass_e'(errClass[2*i +: 2]);
    assign repeatLane[i] = acceptMask[i] & stickyQ[i] & (laneCls != CLS_HW);
  end

  always_comb begin
    strobes.setMe   = |repeatLane;
    strobes.capPriv = |acceptMask;
    strobes.privVal = privLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstHitQ <= 1'b0;
    end else if (beatValid) begin
      burstHitQ <= (beatFirst ? 1'b0 : burstHitQ) | (|errStrobe);
    end
  end

  AST_BURST_DROP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(beatValid) && $past(|errStrobe) && beatValid && !beatFirst)
      |-> (acceptMask == '0)); // R6
endmodule

// File: rtl/afsr_datapath.sv
module afsr_datapath
  import afsr_pkg::*;
#(
  parameter int ERR_COUNT = ErrCount,
  parameter int REG_W     = RegWidth,
  parameter int LSB       = StickyLsb
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ERR_COUNT-1:0] acceptMask,
  input  ctrlStrobe_t          strobes,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [ERR_COUNT-1:0] stickyQ,
  output logic [REG_W-1:0]     rdData,
  output logic                 errPending
);
  logic [ERR_COUNT-1:0] clearMask;
  logic                 clrMe;
  logic                 clrPriv;
  logic                 meQ;
  logic                 privQ;

  assign clearMask = wrEn ? wrData[LSB +: ERR_COUNT] : '0;
  assign clrMe     = wrEn & wrData[MeBit];
  assign clrPriv   = wrEn & wrData[PrivBit];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyQ <= '0;
      meQ     <= 1'b0;
      privQ   <= 1'b0;
    end else begin
      stickyQ <= (stickyQ & ~clearMask) | acceptMask;
      meQ     <= strobes.setMe | (meQ & ~clrMe);
      privQ   <= strobes.capPriv ? strobes.privVal : (privQ & ~clrPriv);
    end
  end

  always_comb begin
    rdData                   = '0;
    rdData[LSB +: ERR_COUNT] = stickyQ;
    rdData[PrivBit]          = privQ;
    rdData[MeBit]            = meQ;
  end

  assign errPending = |stickyQ;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(stickyQ) & ~$past(clearMask) & ~stickyQ) == '0)); // R1
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(clearMask) & ~$past(acceptMask) & stickyQ) == '0)); // R2
  AST_ME_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(meQ) && $past(acceptMask) == '0) |-> !meQ); // R4
  AST_PRIV_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(|acceptMask)) |-> (privQ == $past(strobes.privVal))); // R7
endmodule

// File: rtl/afsr_fault_status.sv
module afsr_fault_status
  import afsr_pkg::*;
#(
  parameter int ERR_COUNT = ErrCount,
  parameter int REG_W     = RegWidth,
  localparam int ClsWidth = 2 * ERR_COUNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ERR_COUNT-1:0] errStrobe,
  input  logic [ClsWidth-1:0]  errClass,
  input  logic                 privLevel,
  input  logic                 beatValid,
  input  logic                 beatFirst,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  output logic                 errPending
);
  logic [ERR_COUNT-1:0] acceptMask;
  logic [ERR_COUNT-1:0] stickyQ;
  ctrlStrobe_t          strobes;

  afsr_ctrl #(.ERR_COUNT(ERR_COUNT)) uCtrl (
    .clk(clk), .rstN(rstN), .errStrobe(errStrobe), .errClass(errClass),
    .privLevel(privLevel), .beatValid(beatValid), .beatFirst(beatFirst),
    .stickyQ(stickyQ), .acceptMask(acceptMask), .strobes(strobes)
  );

  afsr_datapath #(.ERR_COUNT(ERR_COUNT), .REG_W(REG_W), .LSB(StickyLsb)) uData (
    .clk(clk), .rstN(rstN), .acceptMask(acceptMask), .strobes(strobes),
    .wrEn(wrEn), .wrData(wrData), .stickyQ(stickyQ), .rdData(rdData),
    .errPending(errPending)
  );

  AST_PENDING_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(|acceptMask)) |-> errPending); // R9
endmodule

// File: tb/sim_afsr_fault_status.sv
module sim_afsr_fault_status;
  localparam int N = 19;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  errStrobe = '0;
  logic [2*N-1:0] errClass = '0;
  logic          privLevel = 1'b0;
  logic          beatValid = 1'b0;
  logic          beatFirst = 1'b0;
  logic          wrEn = 1'b0;
  logic [63:0]   wrData = '0;
  logic [63:0]   rdData;
  logic          errPending;

  logic [N-1:0]  mSticky = '0;
  logic          mMe = 1'b0;
  logic          mPriv = 1'b0;
  logic          mHit = 1'b0;
  int            testCount = 0;
  int            failCount = 0;

  always #5 clk = ~clk;

  afsr_fault_status u0 (
    .clk(clk), .rstN(rstN), .errStrobe(errStrobe), .errClass(errClass),
    .privLevel(privLevel), .beatValid(beatValid), .beatFirst(beatFirst),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .errPending(errPending)
  );

  function automatic logic [63:0] expWord();
    logic [63:0] w = '0;
    w[51:33] = mSticky;
    w[52]    = mPriv;
    w[53]    = mMe;
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Computes the next model state from the inputs, clocks once, then compares.
  task automatic cycle(string tag);
    logic [N-1:0] acc, clr, nSticky;
    logic drop, meNew, nMe, nPriv, nHit;
    drop  = beatValid && !beatFirst && mHit;
    acc   = drop ? '0 : errStrobe;
    clr   = wrEn ? wrData[51:33] : '0;
    meNew = 1'b0;
    for (int i = 0; i < N; i++)
      if (acc[i] && mSticky[i] && errClass[2*i +: 2] != 2'b00) meNew = 1'b1;
    nSticky = (mSticky & ~clr) | acc;
    nMe     = meNew | (mMe & !(wrEn && wrData[53]));
    nPriv   = (|acc) ? privLevel : (mPriv & !(wrEn && wrData[52]));
    nHit    = beatValid ? ((beatFirst ? 1'b0 : mHit) | (|errStrobe)) : mHit;
    @(posedge clk);
    mSticky = nSticky; mMe = nMe; mPriv = nPriv; mHit = nHit;
    @(negedge clk);
    check(tag, rdData, expWord());
    check("R9 pending", {63'd0, errPending}, {63'd0, |mSticky});
  endtask

  task automatic idle();
    errStrobe = '0; wrEn = 1'b0; wrData = '0; beatValid = 1'b0; beatFirst = 1'b0;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10 reset value", rdData, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 after reset", {rdData[63:1], errPending}, 64'd0);

    // R5: hardware-corrected repeat leaves the flag clear
    idle(); errStrobe[0] = 1'b1; errClass[1:0] = 2'b00; privLevel = 1'b1;
    cycle("R1 first set");
    cycle("R5 hw repeat");
    check("R5 me clear", {63'd0, rdData[53]}, 64'd0);
    check("R7 priv captured", {63'd0, rdData[52]}, 64'd1);
    // R5: new lane together with a hw repeat
    errStrobe = 19'b11; errClass[3:2] = 2'b01; privLevel = 1'b0;
    cycle("R5 different lanes");
    check("R5 me still clear", {63'd0, rdData[53]}, 64'd0);
    // R4: software-correctable repeat
    errStrobe = 19'b10;
    cycle("R4 sw repeat");
    check("R4 me set", {63'd0, rdData[53]}, 64'd1);
    // R2 / R3: write zeros, then write ones everywhere, including the syndrome fields
    idle(); wrEn = 1'b1; wrData = '0;
    cycle("R2 write zero keeps");
    wrData = '1;
    cycle("R3 write all ones");
    check("R3 syndrome fields", {44'd0, rdData[19:16], 7'd0, rdData[8:0]}, 64'd0);
    idle(); cycle("R2 read no clear");
    // R8: event wins over same-cycle clear
    errStrobe[2] = 1'b1; errClass[5:4] = 2'b10; privLevel = 1'b1;
    cycle("R8 setup");
    errStrobe[2] = 1'b1; wrEn = 1'b1; wrData = 64'h0030_0000_0000_0000 | (64'd1 << 35);
    cycle("R8 event wins");
    check("R8 bit2 kept", {63'd0, rdData[35]}, 64'd1);
    idle(); wrEn = 1'b1; wrData = 64'h0030_0000_0000_0000;
    cycle("R8 flags clear");
    // R6: burst drop and reopening
    idle(); beatValid = 1'b1; beatFirst = 1'b1; errStrobe[3] = 1'b1;
    cycle("R6 first subunit logs");
    beatFirst = 1'b0; errStrobe = '0; errStrobe[4] = 1'b1; errClass[9:8] = 2'b10;
    cycle("R6 later subunit dropped");
    check("R6 lane4 clear", {63'd0, rdData[37]}, 64'd0);
    errStrobe = '0; errStrobe[3] = 1'b1; errClass[7:6] = 2'b11;
    cycle("R6 no me from drop");
    beatFirst = 1'b1; errStrobe = '0; errStrobe[4] = 1'b1;
    cycle("R6 new transaction logs");
    idle();

    // Constrained random phase
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < N; i++) begin
        errStrobe[i] = ($urandom_range(0, 9) == 0);
        errClass[2*i +: 2] = 2'($urandom_range(0, 3));
      end
      privLevel = 1'($urandom_range(0, 1));
      wrEn = ($urandom_range(0, 3) == 0);
      wrData = {$urandom(), $urandom()};
      beatValid = ($urandom_range(0, 1) == 1);
      beatFirst = beatValid && ($urandom_range(0, 3) == 0);
      cycle("R1 R4 R6 R7 R8 random");
    end
    idle();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule